// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Line Status

This block sits between a serial receiver and a host. Each time the receiver finishes a character, it delivers the 8-bit value together with two flags: a parity error flag and a framing error flag. The block stores the character and its flags together in a first-in first-out buffer, 16 entries deep by default. The host reads characters from the head of the buffer and reads a status word made of four bits: data ready, overrun, parity error and framing error. The block also reports how many characters the buffer holds.

The character input has no ready signal and cannot be held back. A character that arrives while the buffer is full, in a cycle with no host data read, is dropped and raises overrun. The data read strobe pops one character. A pop on an empty buffer has no effect. When the buffer is empty, the head output keeps the last character that was popped.

The error flags are tied to their own character. They appear in the status only while that character is at the head. They are hidden again when the host reads the status. They come back into view, now for the new character, when the next character moves to the head.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset, the level is 0, every status output is 0 and head_data is 0. All storage is cleared to zero.
- R2: data_ready is 1 exactly when the level is non-zero. It falls only in a cycle after a data read.
- R3: Characters leave the buffer in arrival order. head_data shows the oldest stored character. The level counts from 0 up to DEPTH.
- R4: A character that arrives while the level is DEPTH, with no data read in the same cycle, is discarded. The level stays DEPTH and overrun is 1 from the next cycle.
- R5: Once set, overrun stays set until a status read. A status read clears it, unless a new overrun happens in the same cycle, in which case overrun stays 1.
- R6: parity_err and framing_err show the flags stored with the character at the head, and only while the buffer is not empty.
- R7: A status read hides the parity and framing flags of the current head character from the next cycle on, as long as the head does not change in that cycle.
- R8: When a new character becomes the head, through a pop or a write into an empty buffer, its own flags are shown, whatever status reads happened before.
- R9: When a data read and a new character happen in the same cycle on a non-empty buffer, both take effect and the level does not change. This also holds when the buffer is full, and in that case no overrun is raised.
- R10: A data read on an empty buffer leaves the level at 0, leaves head_data unchanged, and leaves the state of the following characters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a character has been completely received |
| char_data | input | 8 | Received character value |
| char_perr | input | 1 | Parity error flag for this character |
| char_ferr | input | 1 | Framing error flag for this character |
| data_rd | input | 1 | Host pops the head character |
| status_rd | input | 1 | Host reads the status bits |
| head_data | output | 8 | Head character, or the last popped character when the buffer is empty |
| data_ready | output | 1 | Buffer holds at least one character |
| overrun | output | 1 | A character was lost because the buffer was full |
| parity_err | output | 1 | Parity flag of the head character, unless hidden |
| framing_err | output | 1 | Framing flag of the head character, unless hidden |
| level | output | 5 | Number of stored characters (0..DEPTH) |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, random traffic fills the buffer often and the pointers wrap many times. This brings the full-buffer paths within reach in short runs: overrun, a read and a write together while full, and an overrun that coincides with a status read. The directed cases still walk through all four entries to check both ends of the level range.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_char_store.sv
module rx_char_store
  import rx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  rx_entry_t         wr_entry,
  input  logic              rd_en,
  output rx_entry_t         head_entry,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full
);
  rx_entry_t         mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [DATA_W-1:0] hold_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (count == '0);
  assign full       = (count == CW'(DEPTH));
  assign head_entry = mem[rd_ptr];
  assign head_data  = empty ? hold_q : mem[rd_ptr].data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      hold_q <= '0;
      count  <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_ptr] <= wr_entry;
        wr_ptr      <= bump(wr_ptr);
      end
      if (rd_en) begin
        hold_q <= mem[rd_ptr].data;
        rd_ptr <= bump(rd_ptr);
      end
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_rw_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(count));
  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en) |=> empty);
endmodule

// File: rtl/rx_status_bits.sv
module rx_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic head_change,
  input  logic status_rd,
  input  logic head_valid,
  input  logic head_perr,
  input  logic head_ferr,
  output logic overrun,
  output logic perr_out,
  output logic ferr_out
);
  logic mask_q;
  logic ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (head_change)    mask_q <= 1'b0;
      else if (status_rd) mask_q <= 1'b1;
      if (ovf_evt)        ovr_q  <= 1'b1;
      else if (status_rd) ovr_q  <= 1'b0;
    end
  end

  assign overrun  = ovr_q;
  assign perr_out = head_valid && head_perr && !mask_q;
  assign ferr_out = head_valid && head_ferr && !mask_q;

  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !status_rd) |=> overrun);
  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovf_evt) |=> !overrun);
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !head_change) |=> (!perr_out && !ferr_out));
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rx_status_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              data_rd,
  input  logic              status_rd,
  output logic [DATA_W-1:0] head_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              parity_err,
  output logic              framing_err,
  output logic [CW-1:0]     level
);
  rx_entry_t wr_entry, head_entry;
  logic      empty, full, pop, accept, ovf_evt, head_change;

  assign pop         = data_rd && !empty;
  assign accept      = char_valid && (!full || pop);
  assign ovf_evt     = char_valid && full && !pop;
  assign head_change = pop || (accept && empty);
  assign wr_entry    = '{perr: char_perr, ferr: char_ferr, data: char_data};
  assign data_ready  = !empty;

  rx_char_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_entry(wr_entry),
    .rd_en(pop), .head_entry(head_entry), .head_data(head_data),
    .count(level), .empty(empty), .full(full)
  );

  rx_status_bits status_i (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .head_change(head_change),
    .status_rd(status_rd), .head_valid(!empty), .head_perr(head_entry.perr),
    .head_ferr(head_entry.ferr), .overrun(overrun), .perr_out(parity_err),
    .ferr_out(framing_err)
  );

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH) && char_valid && !data_rd) |=> (level == CW'(DEPTH) && overrun));
  p_dr_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(data_rd));
  p_empty_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && data_rd && !char_valid) |=> (level == '0 && $stable(head_data)));
endmodule

// File: tb/rx_status_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_status_fifo_tb_top;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 0, char_perr = 0, char_ferr = 0, data_rd = 0, status_rd = 0;
  logic [7:0] char_data = '0;
  logic [7:0] head_data;
  logic data_ready, overrun, parity_err, framing_err;
  logic [CW-1:0] level;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [9:0] mq[$];
  logic [7:0] m_hold = '0;
  bit m_mask = 0, m_ovr = 0;

  always #2.5 clk = ~clk;

  rx_status_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_head();
    return (mq.size() > 0) ? int'(mq[0][7:0]) : int'(m_hold);
  endfunction
  function automatic int exp_pe();
    return int'(mq.size() > 0 && mq[0][9] && !m_mask);
  endfunction
  function automatic int exp_fe();
    return int'(mq.size() > 0 && mq[0][8] && !m_mask);
  endfunction

  task automatic check_all(input string tag);
    chk({tag, "/R3"}, "level", int'(level), mq.size());
    chk({tag, "/R2"}, "data_ready", int'(data_ready), int'(mq.size() > 0));
    chk({tag, "/R3"}, "head_data", int'(head_data), exp_head());
    chk({tag, "/R5"}, "overrun", int'(overrun), int'(m_ovr));
    chk({tag, "/R6"}, "parity_err", int'(parity_err), exp_pe());
    chk({tag, "/R6"}, "framing_err", int'(framing_err), exp_fe());
  endtask

  task automatic step(input bit cv, input logic [7:0] d, input bit pe, input bit fe,
                      input bit drd, input bit srd, input string tag);
    bit pop, was_empty, full, acc, ovf;
    char_valid = cv; char_data = d; char_perr = pe; char_ferr = fe;
    data_rd = drd; status_rd = srd;
    @(posedge clk);
    was_empty = (mq.size() == 0);
    full      = (mq.size() == DEPTH);
    pop       = drd && !was_empty;
    acc       = cv && (!full || pop);
    ovf       = cv && full && !pop;
    if (pop) begin m_hold = mq[0][7:0]; void'(mq.pop_front()); end
    if (acc) mq.push_back({pe, fe, d});
    if (pop || (acc && was_empty)) m_mask = 0; else if (srd) m_mask = 1;
    if (ovf) m_ovr = 1; else if (srd) m_ovr = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R10: pop on empty keeps head and level
    step(0, 8'h00, 0, 0, 1, 0, "R10 empty pop");
    // R3/R4: fill, then one extra character is dropped
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), i[0], i[1], 0, 0, "R3 fill");
    step(1, 8'hEE, 1, 1, 0, 0, "R4 overrun drop");
    chk("R4", "overrun", int'(overrun), 1);
    // R5: overrun held, then cleared by status read, which also hides flags (R7)
    step(0, 8'h00, 0, 0, 0, 0, "R5 hold");
    step(0, 8'h00, 0, 0, 0, 1, "R5 clear");
    chk("R5", "overrun after status read", int'(overrun), 0);
    // R9: read and write together while full, no overrun
    step(1, 8'h5A, 1, 0, 1, 0, "R9 rw full");
    chk("R9", "level", int'(level), DEPTH);
    // R7: status read hides head flags; R8: next head shows its own
    step(0, 8'h00, 0, 0, 0, 1, "R7 mask");
    chk("R7", "parity hidden", int'(parity_err), 0);
    step(0, 8'h00, 0, 0, 1, 0, "R8 new head");
    // R5: overrun and status read in same cycle keep overrun set
    step(1, 8'h77, 0, 0, 0, 0, "R5 refill");
    step(1, 8'h78, 0, 1, 0, 1, "R5 set wins");
    chk("R5", "overrun set wins", int'(overrun), 1);
    // drain to empty, then R10 again and head keeps last value
    for (int i = 0; i < DEPTH + 1; i++) step(0, 8'h00, 0, 0, 1, 0, "R2 drain");
    chk("R10", "head after drain", int'(head_data), int'(m_hold));
    // R8: status read while empty, then write into empty shows flags
    step(0, 8'h00, 0, 0, 0, 1, "R8 srd empty");
    step(1, 8'hC3, 1, 1, 0, 0, "R8 write empty");
    chk("R8", "parity shown", int'(parity_err), 1);

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      step(r < 55, 8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
           $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 20, "random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule